// File: doc/BRIEF.md
# Burst Flash Read Configuration Logic

This block is the read-control side of a 16-bit NOR flash that can serve both plain asynchronous reads and clocked bursts. A 16-bit read configuration register selects between the two. Software programs it with a two-write command sequence. The new register value travels on the address lines, and the data lines carry only the command codes.

In synchronous mode the block latches a start address when address-valid is low. It then waits the programmed latency and produces one word per clock. The word addresses come from an internal generator, which either wraps inside an aligned window of 4, 8 or 16 words or counts straight on.

The memory array is a fixed lookup, so every read result can be predicted from the address alone. All logic runs on the rising clock edge. The asynchronous active-low reset is released through a two-stage synchronizer, and any reset returns the block to asynchronous reads.

Top module: `burst_read_ctl`

## Requirements
- R1: After any reset the configuration register holds 0xFFFF (bit 15 set, asynchronous mode). An asynchronous read then returns the array word, and this includes a reset taken while in synchronous mode.
- R2: In asynchronous mode, with chip enable and output enable both low, `dq_oe` is 1 and `dq_out` equals `addr[15:0] ^ 16'hC35A`. The output follows the address combinationally.
- R3: `dq_oe` is 0 whenever `ce_n` or `oe_n` is high.
- R4: A write is the rising edge of `we_n` (sampled on `clk`) while `ce_n` is low. A write whose `dq_in[7:0]` is 0x60, followed by a write whose `dq_in[7:0]` is 0x03, loads `addr[15:0]` of the second write into the configuration register. Bit 15 = 0 selects synchronous burst mode.
- R5: A confirm write (0x03) not directly preceded by a setup write (0x60) leaves the register unchanged. This includes a setup that is followed by any other code before the confirm.
- R6: In synchronous mode the start address is captured on the first clock edge at which `adv_n` is low, `ce_n` is low and `we_n` is high. Later edges while `adv_n` stays low do not capture again.
- R7: The latency L is register bits 13:11. `dq_oe` stays 0 from before capture until L edges after the capture edge. After that edge the word at the start address is driven.
- R8: Each further clock edge advances the burst address by one. With bit 3 = 0 the address wraps inside the aligned window of the burst length. With bit 3 = 1 it increments without wrapping.
- R9: The burst length is taken from bits 2:0: 001 = 4 words, 010 = 8, 011 = 16, and 111 = continuous, which never wraps. Every other code acts as 8 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge valid |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a write takes effect on its rising edge |
| adv_n | input | 1 | Address valid, active low |
| addr | input | ADDR_W | Word address; also carries the configuration value |
| dq_in | input | 16 | Write data (command codes) |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
Asynchronous reads respond within the same cycle, so the bench checks them a short delay after driving the address. A register write takes effect on the clock edge that sees `we_n` high after a low cycle, and the bench reads the new mode only after that edge. For a burst, the capture edge is the first edge with `adv_n` low. The first word is due after the edge L later, and each following word one edge after the previous one. The bench therefore counts exactly L falling edges after the capture edge and then compares one word per falling edge. Reset release passes two synchronizer flops, so checks resume only after several idle cycles.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam logic [15:0] CFG_RESET   = 16'hFFFF;
  localparam logic [7:0]  CMD_SETUP   = 8'h60;
  localparam logic [7:0]  CMD_CONFIRM = 8'h03;
  localparam logic [15:0] ARRAY_KEY   = 16'hC35A;
  localparam int          LAT_W       = 3;
  localparam int          WIN_W       = 4;

  typedef struct packed {
    logic             sync_mode;
    logic [LAT_W-1:0] latency;
    logic             straight;   // increment without wrapping
    logic [WIN_W-1:0] win_mask;   // low address bits that wrap
  } rd_cfg_t;

  function automatic rd_cfg_t decode_cfg(input logic [15:0] r);
    rd_cfg_t d;
    d.sync_mode = ~r[15];
    d.latency   = r[13:11];
    d.straight  = r[3] | (r[2:0] == 3'b111);
    case (r[2:0])
      3'b001:  d.win_mask = 4'h3;
      3'b011:  d.win_mask = 4'hF;
      default: d.win_mask = 4'h7;
    endcase
    return d;
  endfunction

  function automatic logic [15:0] array_word(input logic [15:0] a);
    return a ^ ARRAY_KEY;
  endfunction
endpackage

// File: rtl/brc_rst_sync.sv
module brc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/brc_cfg_reg.sv
module brc_cfg_reg
  import brc_pkg::*;
(
  input  logic        clk,
  input  logic        srst_n,
  input  logic        ce_n,
  input  logic        we_n,
  input  logic [15:0] cfg_in,
  input  logic [7:0]  cmd,
  output logic [15:0] cfg_q,
  output logic        pend_q
);
  logic        we_q;
  logic        we_rise;
  logic [15:0] cfg_d;
  logic        pend_d;

  assign we_rise = ~ce_n & ~we_q & we_n;

  always_comb begin
    cfg_d  = cfg_q;
    pend_d = pend_q;
    if (we_rise) begin
      if (pend_q && cmd == CMD_CONFIRM) begin
        cfg_d  = cfg_in;
        pend_d = 1'b0;
      end else begin
        pend_d = (cmd == CMD_SETUP);
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      we_q   <= 1'b1;
      cfg_q  <= CFG_RESET;
      pend_q <= 1'b0;
    end else begin
      we_q   <= we_n;
      cfg_q  <= cfg_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/brc_burst_gen.sv
module brc_burst_gen
  import brc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             adv_n,
  input  logic [AW-1:0]    addr,
  input  rd_cfg_t          cfg,
  output logic [AW-1:0]    burst_addr,
  output logic [LAT_W-1:0] lat_cnt,
  output logic             burst_valid
);
  logic             armed_q, armed_d;
  logic             active_q, active_d;
  logic [LAT_W-1:0] cnt_d;
  logic [AW-1:0]    addr_d;
  logic [AW-1:0]    win;
  logic [AW-1:0]    step;
  logic             capture;

  assign win     = {{(AW-WIN_W){1'b0}}, cfg.win_mask};
  assign step    = burst_addr + 1'b1;
  assign capture = cfg.sync_mode & ~ce_n & we_n & ~adv_n & ~armed_q;

  always_comb begin
    armed_d  = armed_q;
    active_d = active_q;
    cnt_d    = lat_cnt;
    addr_d   = burst_addr;
    if (ce_n || adv_n) armed_d = 1'b0;
    else if (capture)  armed_d = 1'b1;
    if (ce_n || !cfg.sync_mode) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (capture) begin
      active_d = 1'b1;
      cnt_d    = cfg.latency;
    end else if (active_q && lat_cnt != '0) begin
      cnt_d    = lat_cnt - 1'b1;
    end
    if (capture) begin
      addr_d = addr;
    end else if (active_q && lat_cnt == '0) begin
      if (cfg.straight) addr_d = step;
      else              addr_d = (burst_addr & ~win) | (step & win);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      armed_q    <= 1'b0;
      active_q   <= 1'b0;
      lat_cnt    <= '0;
      burst_addr <= '0;
    end else begin
      armed_q    <= armed_d;
      active_q   <= active_d;
      lat_cnt    <= cnt_d;
      burst_addr <= addr_d;
    end
  end

  assign burst_valid = active_q & (lat_cnt == '0);
endmodule

// File: rtl/burst_read_ctl.sv
module burst_read_ctl
  import brc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic              dq_oe
);
  logic             srst_n;
  logic [15:0]      cfg_q;
  logic             cmd_pend;
  rd_cfg_t          cfg_dec;
  logic [ADDR_W-1:0] burst_addr;
  logic [LAT_W-1:0] lat_cnt;
  logic             burst_valid;
  logic [15:0]      rd_addr;

  brc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  brc_cfg_reg u_cfg (
    .clk(clk), .srst_n(srst_n), .ce_n(ce_n), .we_n(we_n),
    .cfg_in(addr[15:0]), .cmd(dq_in[7:0]),
    .cfg_q(cfg_q), .pend_q(cmd_pend)
  );

  assign cfg_dec = decode_cfg(cfg_q);

  brc_burst_gen #(.AW(ADDR_W)) u_gen (
    .clk(clk), .srst_n(srst_n), .ce_n(ce_n), .we_n(we_n), .adv_n(adv_n),
    .addr(addr), .cfg(cfg_dec), .burst_addr(burst_addr),
    .lat_cnt(lat_cnt), .burst_valid(burst_valid)
  );

  assign rd_addr = cfg_dec.sync_mode ? burst_addr[15:0] : addr[15:0];
  assign dq_out  = array_word(rd_addr);
  assign dq_oe   = ~ce_n & ~oe_n & (cfg_dec.sync_mode ? burst_valid : 1'b1);
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          srst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          adv_n,
  input logic [AW-1:0] addr,
  input logic [15:0]   dq_in,
  input logic          dq_oe,
  input logic [15:0]   cfg_q,
  input logic          cmd_pend,
  input logic [AW-1:0] burst_addr,
  input logic [2:0]    lat_cnt,
  input logic          burst_valid
);
  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!srst_n)
    (ce_n || oe_n) |-> !dq_oe);                                     // R3

  AST_CFG_LOADED: assert property (@(posedge clk) disable iff (!srst_n)
    ($rose(we_n) && !ce_n && cmd_pend && dq_in[7:0] == 8'h03)
      |=> cfg_q == $past(addr[15:0]));                              // R4

  AST_CFG_STEADY: assert property (@(posedge clk) disable iff (!srst_n)
    !$rose(we_n) |=> $stable(cfg_q));                               // R5

  AST_NO_EARLY_DATA: assert property (@(posedge clk) disable iff (!srst_n)
    (lat_cnt != 3'd0) |-> !dq_oe);                                  // R7

  AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!srst_n)
    (burst_valid && adv_n && !ce_n) |=> burst_addr != $past(burst_addr)); // R8
endmodule

bind burst_read_ctl brc_checker #(.AW(ADDR_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .adv_n(adv_n), .addr(addr), .dq_in(dq_in), .dq_oe(dq_oe),
  .cfg_q(cfg_q), .cmd_pend(cmd_pend), .burst_addr(burst_addr),
  .lat_cnt(lat_cnt), .burst_valid(burst_valid)
);

// File: tb/test_burst_read_ctl.sv
module test_burst_read_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, oe_n, we_n, adv_n;
  logic [15:0] addr;
  logic [15:0] dq_in;
  logic [15:0] dq_out;
  logic        dq_oe;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  burst_read_ctl i_burst_read_ctl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .adv_n(adv_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // entry: config, start, five expected word addresses
  localparam logic [15:0] VEC [0:6][0:6] = '{
    '{16'h10C2, 16'h0016, 16'h0016, 16'h0017, 16'h0010, 16'h0011, 16'h0012}, // R8 8 wrap
    '{16'h10C1, 16'h0102, 16'h0102, 16'h0103, 16'h0100, 16'h0101, 16'h0102}, // R9 4 wrap
    '{16'h10C3, 16'h003E, 16'h003E, 16'h003F, 16'h0030, 16'h0031, 16'h0032}, // R9 16 wrap
    '{16'h10CA, 16'h0016, 16'h0016, 16'h0017, 16'h0018, 16'h0019, 16'h001A}, // R8 no wrap
    '{16'h10C7, 16'h00FE, 16'h00FE, 16'h00FF, 16'h0100, 16'h0101, 16'h0102}, // R9 continuous
    '{16'h10C0, 16'h0016, 16'h0016, 16'h0017, 16'h0010, 16'h0011, 16'h0012}, // R9 reserved
    '{16'h20C1, 16'h0203, 16'h0203, 16'h0200, 16'h0201, 16'h0202, 16'h0203}  // R7 latency 4
  };

  function automatic logic [15:0] word_of(input logic [15:0] a);
    return a ^ 16'hC35A;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk_word(input string req, input logic [15:0] exp);
    n_chk++;
    if (dq_oe !== 1'b1 || dq_out !== exp) begin
      n_bad++;
      $display("FAIL %s: actual oe=%b data=%h expected oe=1 data=%h", req, dq_oe, dq_out, exp);
    end
  endtask

  task automatic chk_off(input string req);
    n_chk++;
    if (dq_oe !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: actual oe=%b expected oe=0", req, dq_oe);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; dq_in = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; adv_n = 1'b1;
  endtask

  task automatic async_read(input string req, input logic [15:0] a);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a; #1;
    chk_word(req, word_of(a));
    @(negedge clk); idle();
  endtask

  task automatic run_vec(input int i);
    int lat;
    lat = int'(VEC[i][0][13:11]);
    wr(16'h0000, 16'h0060);
    wr(VEC[i][0], 16'h0003);
    @(negedge clk); ce_n = 1'b0; adv_n = 1'b0; oe_n = 1'b0; addr = VEC[i][1]; #1;
    chk_off("R7 before capture");
    @(negedge clk); adv_n = 1'b1; addr = 16'hBEEF; #1;
    if (lat > 0) chk_off("R7 inside latency");
    repeat (lat) @(negedge clk);
    #1;
    for (int k = 0; k < 5; k++) begin
      chk_word("R8/R9 burst word", word_of(VEC[i][2+k]));
      @(negedge clk); #1;
    end
    idle();
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; idle(); addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 idle bus, R1 default asynchronous read
    #1 chk_off("R3 after reset");
    async_read("R1 reset async read", 16'h1234);
    async_read("R2 async read", 16'hFFFF);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; #1;
    chk_off("R3 ce high");
    @(negedge clk); idle();

    // R5 confirm without setup, and setup broken by other code
    wr(16'h10C2, 16'h0003);
    async_read("R5 lone confirm ignored", 16'h0456);
    wr(16'h0000, 16'h0060);
    wr(16'h0000, 16'h0040);
    wr(16'h10C2, 16'h0003);
    async_read("R5 broken setup ignored", 16'h0789);

    // R4 R7 R8 R9 table of bursts
    for (int i = 0; i < 7; i++) run_vec(i);

    // R6: adv held low, second edge must not re-capture; latency 1
    wr(16'h0000, 16'h0060);
    wr(16'h08C2, 16'h0003);
    @(negedge clk); ce_n = 1'b0; adv_n = 1'b0; oe_n = 1'b0; addr = 16'h0045;
    @(negedge clk); addr = 16'h0099; #1;
    chk_off("R7 latency 1");
    @(negedge clk); adv_n = 1'b1; #1;
    chk_word("R6 start kept", word_of(16'h0045));
    @(negedge clk); #1;
    chk_word("R6 next word", word_of(16'h0046));
    @(negedge clk); oe_n = 1'b1; #1;
    chk_off("R3 oe high in burst");
    @(negedge clk); idle();

    // R1 reset from synchronous mode
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    async_read("R1 reset leaves sync mode", 16'h0ACE);

    summary();
  end
endmodule